// File: doc/BRIEF.md
# Prioritized Interrupt Request Core

This block gathers a set of interrupt request lines (eight by default) and raises a single interrupt towards a processor. It keeps three registers of one bit per line:
- **Pending** holds the latched requests.
- **Mask** holds one disable bit per line.
- **In-service** records the requests that the processor has taken and not yet retired.

Line 0 has the highest priority and the last line has the lowest. The interrupt output is raised only when an unmasked pending request outranks every request already in service. Nested service is therefore limited to strictly higher priorities.

A configuration strobe sets the following, and moves the core out of its reset state into operational mode:
- the vector base;
- the trigger style, edge or level;
- automatic retirement.

A one-cycle acknowledge pulse moves the winning request from pending into service. It also latches an output vector, made of the base in the upper bits and the line number in the low bits. A non-specific end-of-interrupt strobe retires the highest-priority in-service entry. With automatic retirement configured, the acknowledge never marks anything in service. A separate address decoder drives the strobes. The register contents are returned on a selected read port.

Top module: `irq_prio_core`

## Requirements
- R1: After reset the pending and in-service registers read 0, the mask reads all ones, int_out is low and vec_out is 0. Until the first configuration strobe, no request is latched, int_out stays low and mask writes are ignored.
- R2: A cfg_we pulse loads the base, trigger style and automatic retirement option. It clears the pending, in-service and mask registers, and enters operational mode. vec_out is not changed by it.
- R3: In edge style (cfg_level=0), a line that is low in one cycle and high in the next sets its pending bit one clock later. The bit stays set after the line falls, until that line wins an acknowledge.
- R4: In level style (cfg_level=1), each pending bit follows its request line with one clock of delay.
- R5: int_out is high exactly when some pending, unmasked line has a lower index than the lowest-indexed set in-service bit, or when the in-service register is empty and some pending, unmasked line exists.
- R6: An inta pulse with a winner does three things in the same clock: it sets the winner's in-service bit, clears its pending bit, and loads vec_out = {base, winner index}. vec_out holds that value until the next inta.
- R7: An inta pulse with no eligible request loads vec_out = {base, all ones in the index field} and leaves the pending and in-service registers unchanged.
- R8: A non-specific end-of-interrupt pulse (eoi_cmd) clears only the lowest-indexed set in-service bit. After that, requests of equal or lower priority may raise int_out again.
- R9: With automatic retirement configured (cfg_auto_eoi=1), an acknowledge never sets any in-service bit.
- R10: A set mask bit removes its line from arbitration but keeps its pending bit. Clearing the mask bit lets the line interrupt again. Mask writes take effect at any time in operational mode.
- R11: rd_data shows one register, chosen by rd_sel: 0 selects pending, 1 selects in-service, 2 selects mask, and 3 returns zero.
- R12: When eoi_cmd and inta arrive in the same clock, the retirement applies to the old in-service contents before the new winner's bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_REQ | Request lines, bit 0 highest priority |
| cfg_we | input | 1 | Configuration strobe |
| cfg_level | input | 1 | 1 selects level style, 0 selects edge style |
| cfg_auto_eoi | input | 1 | 1 enables automatic retirement |
| cfg_base | input | VEC_W-log2(NUM_REQ) | Vector base bits |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | NUM_REQ | New mask value |
| eoi_cmd | input | 1 | Non-specific end-of-interrupt strobe |
| inta | input | 1 | Acknowledge pulse |
| rd_sel | input | 2 | Read register select |
| rd_data | output | NUM_REQ | Selected register contents |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | VEC_W | Vector of the last acknowledge |

## Verification
The embedded properties are checked every cycle. They cover:
- the pending register staying empty before configuration;
- edge-latched bits holding until they are acknowledged;
- an acknowledge marking its winner in service;
- vector stability between acknowledges;
- the all-ones index on an empty acknowledge;
- the empty in-service register under automatic retirement;
- each retirement removing exactly one in-service bit.

Only the directed scenarios can show the following:
- the actual vector values;
- the nesting rule, where a lower line is blocked while a higher one is in service;
- a masked request that survives until it is unmasked;
- the level-style follow behaviour;
- the ordering of a retirement and an acknowledge that arrive in the same clock.

// File: rtl/irq_core_pkg.sv
package irq_core_pkg;
   typedef enum logic [1:0] {
      SEL_PEND  = 2'd0,
      SEL_SERV  = 2'd1,
      SEL_MASK  = 2'd2,
      SEL_NONE  = 2'd3
   } rd_sel_e;
endpackage

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
   parameter int WIDTH = 8,
   localparam int IDW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic [WIDTH-1:0] vec_in,
   output logic [WIDTH-1:0] onehot,
   output logic [IDW-1:0]   idx,
   output logic             any
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("irq_lowest_pick: WIDTH must be at least 2");
      end
   endgenerate

   always_comb begin
      any    = |vec_in;
      onehot = vec_in & (~vec_in + {{(WIDTH-1){1'b0}}, 1'b1});
      idx    = '0;
      for (int i = WIDTH - 1; i >= 0; i--) begin
         if (vec_in[i]) idx = IDW'(i);
      end
   end
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             level,
   input  logic             clr_all,
   input  logic [WIDTH-1:0] irq_in,
   input  logic [WIDTH-1:0] ack_clr,
   output logic [WIDTH-1:0] irr_q
);
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= irq_in;
   end

   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_line
         always_ff @(posedge clk) begin
            if (!rst_n || clr_all || !enable) begin
               irr_q[b] <= 1'b0;
            end else if (level) begin
               irr_q[b] <= irq_in[b] & ~ack_clr[b];
            end else begin
               irr_q[b] <= (irr_q[b] | (irq_in[b] & ~prev_q[b])) & ~ack_clr[b];
            end
         end

         // R3
         edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (enable && !level && !clr_all && irr_q[b] && !ack_clr[b]) |=> irr_q[b])
            else $error("edge-latched request dropped before acknowledge");
      end
   endgenerate
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_all,
   input  logic             eoi,
   input  logic [WIDTH-1:0] set_oh,
   output logic [WIDTH-1:0] isr_q,
   output logic [WIDTH-1:0] top_oh
);
   localparam int IDW = $clog2(WIDTH);

   logic [IDW-1:0] top_idx;
   logic           top_any;
   logic [WIDTH-1:0] retired;

   irq_lowest_pick #(.WIDTH(WIDTH)) u_top (
      .vec_in (isr_q),
      .onehot (top_oh),
      .idx    (top_idx),
      .any    (top_any)
   );

   assign retired = eoi ? (isr_q & ~top_oh) : isr_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr_all) isr_q <= '0;
      else                   isr_q <= retired | set_oh;
   end

   // R8
   eoi_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !clr_all && set_oh == '0 && isr_q != '0)
      |=> ($countones(isr_q) == $countones($past(isr_q)) - 1))
      else $error("retirement did not remove exactly one in-service bit");

   // R8
   eoi_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !clr_all && set_oh == '0 && top_any)
      |=> ((isr_q & $past(top_oh)) == '0))
      else $error("retirement left the highest-priority bit set");
endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core
   import irq_core_pkg::*;
#(
   parameter int NUM_REQ = 8,
   parameter int VEC_W   = 8,
   localparam int IDW    = $clog2(NUM_REQ),
   localparam int BASE_W = VEC_W - IDW
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_REQ-1:0] irq_in,
   input  logic               cfg_we,
   input  logic               cfg_level,
   input  logic               cfg_auto_eoi,
   input  logic [BASE_W-1:0]  cfg_base,
   input  logic               mask_we,
   input  logic [NUM_REQ-1:0] mask_wdata,
   input  logic               eoi_cmd,
   input  logic               inta,
   input  logic [1:0]         rd_sel,
   output logic [NUM_REQ-1:0] rd_data,
   output logic               int_out,
   output logic [VEC_W-1:0]   vec_out
);
   generate
      if (NUM_REQ < 2 || (1 << IDW) != NUM_REQ) begin : g_bad_req
         $error("irq_prio_core: NUM_REQ must be a power of two, at least 2");
      end
      if (BASE_W < 1) begin : g_bad_vec
         $error("irq_prio_core: VEC_W must exceed log2(NUM_REQ)");
      end
   endgenerate

   logic               op_q, level_q, auto_q;
   logic [BASE_W-1:0]  base_q;
   logic [NUM_REQ-1:0] imr_q, irr_q, isr_q, isr_top_oh;
   logic [NUM_REQ-1:0] pending, allowed, eligible;
   logic [NUM_REQ-1:0] win_oh, ack_clr, isr_set;
   logic [IDW-1:0]     win_idx;
   logic               win_any, ack_go, grant;
   logic [VEC_W-1:0]   vec_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q    <= 1'b0;
         level_q <= 1'b0;
         auto_q  <= 1'b0;
         base_q  <= '0;
         imr_q   <= '1;
      end else if (cfg_we) begin
         op_q    <= 1'b1;
         level_q <= cfg_level;
         auto_q  <= cfg_auto_eoi;
         base_q  <= cfg_base;
         imr_q   <= '0;
      end else if (mask_we && op_q) begin
         imr_q   <= mask_wdata;
      end
   end

   irq_req_latch #(.WIDTH(NUM_REQ)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (op_q),
      .level   (level_q),
      .clr_all (cfg_we),
      .irq_in  (irq_in),
      .ack_clr (ack_clr),
      .irr_q   (irr_q)
   );

   irq_inservice #(.WIDTH(NUM_REQ)) u_serv (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_all (cfg_we),
      .eoi     (eoi_cmd && op_q),
      .set_oh  (isr_set),
      .isr_q   (isr_q),
      .top_oh  (isr_top_oh)
   );

   // all lines strictly above the highest in-service one; all ones if none
   assign pending  = irr_q & ~imr_q;
   assign allowed  = isr_top_oh - {{(NUM_REQ-1){1'b0}}, 1'b1};
   assign eligible = pending & allowed;

   irq_lowest_pick #(.WIDTH(NUM_REQ)) u_win (
      .vec_in (eligible),
      .onehot (win_oh),
      .idx    (win_idx),
      .any    (win_any)
   );

   assign ack_go  = inta && op_q && !cfg_we;
   assign grant   = ack_go && win_any;
   assign ack_clr = grant ? win_oh : '0;
   assign isr_set = (grant && !auto_q) ? win_oh : '0;
   assign int_out = op_q && win_any;

   always_ff @(posedge clk) begin
      if (!rst_n)      vec_q <= '0;
      else if (ack_go) vec_q <= {base_q, (win_any ? win_idx : {IDW{1'b1}})};
   end
   assign vec_out = vec_q;

   always_comb begin
      unique case (rd_sel_e'(rd_sel))
         SEL_PEND: rd_data = irr_q;
         SEL_SERV: rd_data = isr_q;
         SEL_MASK: rd_data = imr_q;
         default:  rd_data = '0;
      endcase
   end

   // R1
   pre_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_q |-> (irr_q == '0 && isr_q == '0))
      else $error("request latched before configuration");

   // R6
   ack_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && !auto_q) |=> ((isr_q & $past(win_oh)) != '0))
      else $error("acknowledged line not marked in service");

   // R6
   vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_go |=> $stable(vec_out))
      else $error("vector changed without acknowledge");

   // R7
   spur_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_go && !win_any) |=> (vec_out[IDW-1:0] == {IDW{1'b1}}))
      else $error("empty acknowledge returned wrong index");

   // R9
   auto_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      auto_q |-> (isr_q == '0))
      else $error("in-service bit set under automatic retirement");
endmodule

// File: tb/sim_irq_prio_core.sv
`timescale 1ns/1ps
module sim_irq_prio_core;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] irq_in;
   logic       cfg_we, cfg_level, cfg_auto_eoi;
   logic [4:0] cfg_base;
   logic       mask_we;
   logic [7:0] mask_wdata;
   logic       eoi_cmd, inta;
   logic [1:0] rd_sel;
   logic [7:0] rd_data;
   logic       int_out;
   logic [7:0] vec_out;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   irq_prio_core u0 (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .cfg_we(cfg_we), .cfg_level(cfg_level), .cfg_auto_eoi(cfg_auto_eoi),
      .cfg_base(cfg_base), .mask_we(mask_we), .mask_wdata(mask_wdata),
      .eoi_cmd(eoi_cmd), .inta(inta), .rd_sel(rd_sel), .rd_data(rd_data),
      .int_out(int_out), .vec_out(vec_out)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic rd(logic [1:0] sel, output logic [7:0] v);
      rd_sel = sel;
      #1 v = rd_data;
   endtask

   task automatic chk_reg(string req, logic [1:0] sel, logic [7:0] exp);
      logic [7:0] v;
      rd(sel, v);
      chk(req, (sel == 2'd0) ? "pending" : (sel == 2'd1) ? "in-service" :
               (sel == 2'd2) ? "mask" : "unused", v, exp);
   endtask

   task automatic chk_int(string req, logic exp);
      chk(req, "int_out", {7'd0, int_out}, {7'd0, exp});
   endtask

   task automatic configure(logic [4:0] base, logic lvl, logic aut);
      cfg_base = base; cfg_level = lvl; cfg_auto_eoi = aut; cfg_we = 1'b1;
      step();
      cfg_we = 1'b0;
   endtask

   task automatic ack();
      inta = 1'b1; step(); inta = 1'b0;
   endtask

   task automatic eoi();
      eoi_cmd = 1'b1; step(); eoi_cmd = 1'b0;
   endtask

   task automatic t_reset();
      chk_int("R1", 1'b0);
      chk("R1", "vec_out", vec_out, 8'h00);
      chk_reg("R1", 2'd0, 8'h00);
      chk_reg("R1", 2'd1, 8'h00);
      chk_reg("R1", 2'd2, 8'hFF);
      mask_wdata = 8'h00; mask_we = 1'b1; step(); mask_we = 1'b0;
      chk_reg("R1", 2'd2, 8'hFF);
      irq_in = 8'h01; step();
      chk_reg("R1", 2'd0, 8'h00);
      chk_int("R1", 1'b0);
      irq_in = 8'h00; step();
   endtask

   task automatic t_config();
      configure(5'h12, 1'b0, 1'b0);
      chk_reg("R2", 2'd2, 8'h00);
      chk("R2", "vec_out", vec_out, 8'h00);
      chk_reg("R11", 2'd3, 8'h00);
   endtask

   task automatic t_edge();
      irq_in = 8'h08; step();
      chk_reg("R3", 2'd0, 8'h08);
      chk_int("R5", 1'b1);
      irq_in = 8'h00; step();
      chk_reg("R3", 2'd0, 8'h08);
      ack();
      chk("R6", "vec_out", vec_out, 8'h93);
      chk_reg("R6", 2'd1, 8'h08);
      chk_reg("R6", 2'd0, 8'h00);
      chk_int("R5", 1'b0);
      eoi();
      chk_reg("R8", 2'd1, 8'h00);
   endtask

   task automatic t_prio();
      irq_in = 8'h24; step();
      ack();
      chk("R5", "vec_out", vec_out, 8'h92);
      chk_reg("R6", 2'd1, 8'h04);
      chk_reg("R6", 2'd0, 8'h20);
      chk_int("R5", 1'b0);
      irq_in = 8'h26; step();
      chk_int("R5", 1'b1);
      ack();
      chk("R6", "vec_out", vec_out, 8'h91);
      chk_reg("R6", 2'd1, 8'h06);
      chk_int("R5", 1'b0);
      eoi();
      chk_reg("R8", 2'd1, 8'h04);
      chk_int("R8", 1'b0);
      eoi();
      chk_reg("R8", 2'd1, 8'h00);
      chk_int("R8", 1'b1);
      ack();
      chk("R6", "vec_out", vec_out, 8'h95);
      step(); step();
      chk("R6", "vec_out held", vec_out, 8'h95);
      eoi();
      irq_in = 8'h00; step();
   endtask

   task automatic t_mask();
      mask_wdata = 8'h04; mask_we = 1'b1; step(); mask_we = 1'b0;
      chk_reg("R10", 2'd2, 8'h04);
      irq_in = 8'h04; step();
      chk_reg("R10", 2'd0, 8'h04);
      chk_int("R10", 1'b0);
      mask_wdata = 8'h00; mask_we = 1'b1; step(); mask_we = 1'b0;
      chk_int("R10", 1'b1);
      ack();
      chk("R10", "vec_out", vec_out, 8'h92);
      eoi();
      irq_in = 8'h00; step();
   endtask

   task automatic t_spurious();
      ack();
      chk("R7", "vec_out", vec_out, 8'h97);
      chk_reg("R7", 2'd1, 8'h00);
      chk_reg("R7", 2'd0, 8'h00);
   endtask

   task automatic t_same_cycle();
      irq_in = 8'h10; step();
      ack();
      chk_reg("R12", 2'd1, 8'h10);
      irq_in = 8'h14; step();
      chk_int("R12", 1'b1);
      inta = 1'b1; eoi_cmd = 1'b1; step(); inta = 1'b0; eoi_cmd = 1'b0;
      chk_reg("R12", 2'd1, 8'h04);
      chk("R12", "vec_out", vec_out, 8'h92);
      eoi();
      chk_reg("R12", 2'd1, 8'h00);
      irq_in = 8'h00; step();
   endtask

   task automatic t_level_auto();
      configure(5'h04, 1'b1, 1'b1);
      irq_in = 8'h40; step();
      chk_reg("R4", 2'd0, 8'h40);
      chk_int("R4", 1'b1);
      irq_in = 8'h00; step();
      chk_reg("R4", 2'd0, 8'h00);
      chk_int("R4", 1'b0);
      irq_in = 8'h10; step();
      ack();
      chk("R9", "vec_out", vec_out, 8'h24);
      chk_reg("R9", 2'd1, 8'h00);
      step();
      chk_int("R9", 1'b1);
      irq_in = 8'h00; step();
   endtask

   initial begin
      rst_n = 1'b0; irq_in = '0; cfg_we = 0; cfg_level = 0; cfg_auto_eoi = 0;
      cfg_base = '0; mask_we = 0; mask_wdata = '0; eoi_cmd = 0; inta = 0;
      rd_sel = 2'd0;
      step(); step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_config();
      t_edge();
      t_prio();
      t_mask();
      t_spurious();
      t_same_cycle();
      t_level_auto();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule